// File: doc/BRIEF.md
# Fuse Macro Read Sequencer

This block reads a run of consecutive bytes out of a one-time-programmable fuse macro. It drives the macro's control word with the pin timing the macro needs, samples the macro's byte output and hands each byte back to the requester. A request gives a 10-bit start address and a byte count. The block then opens a load session and steps through the addresses one byte at a time. For each byte it sets the address, raises the strobe, captures the data and releases the strobe. At the end it parks the macro in standby.

Every settle interval lasts one microsecond. The block gets each interval from a cycle counter, so the `CLK_HZ` parameter fixes the interval length in cycles. The macro is treated as read-only. A write request is acknowledged and does nothing else.

The state machine has six states:
- `S_STANDBY`: idle, macro in standby.
- `S_OPEN`: session opening, load asserted.
- `S_ADDR_CLR`: address field cleared.
- `S_ADDR_SET`: address presented.
- `S_STROBE`: strobe high.
- `S_RELEASE`: strobe low again.

The transitions are:
- `S_STANDBY` to `S_OPEN` on an accepted start with a non-zero count.
- `S_OPEN` to `S_ADDR_CLR` when the interval expires.
- `S_ADDR_CLR` to `S_ADDR_SET` after one cycle.
- `S_ADDR_SET` to `S_STROBE` when the interval expires.
- `S_STROBE` to `S_RELEASE` when the interval expires.
- `S_RELEASE` to `S_ADDR_CLR` when the interval expires and bytes remain.
- `S_RELEASE` to `S_STANDBY` when the interval expires on the last byte.

Top module: `fuse_read_seq`

## Requirements
- R1: After reset, `macro_ctrl` is 16'h0009 (standby), and `busy`, `data_valid`, `done` and `wr_done` are low. The control word fields are: address at [15:6], program-enable-bar at bit 3, load at bit 2, strobe at bit 1, chip-select-bar at bit 0, and bits [5:4] always zero.
- R2: When `start` is accepted with a non-zero count, `busy` rises and `macro_ctrl` becomes 16'h000C (load and program-enable-bar high, address zero) in the cycle after the start edge. It holds there for one interval.
- R3: For each byte, `macro_ctrl` first shows 16'h000C for exactly one cycle with the address cleared. It then shows `{addr,6'b001100}` for one interval.
- R4: Strobe (bit 1) then stays high for one interval with the address unchanged. The block captures `fuse_q` on the last strobe cycle and presents it on `data` with a one-cycle `data_valid` pulse in the first cycle after strobe falls.
- R5: After strobe falls, the word `{addr,6'b001100}` holds for one interval before the next byte or the return to standby.
- R6: The address starts at `start_addr` and rises by one per byte, wrapping from 1023 to 0. Bytes come out in address order, one per requested count.
- R7: After the last byte's release interval, `macro_ctrl` returns to 16'h0009, `busy` falls and `done` pulses for exactly one cycle, all in the same cycle.
- R8: A `start` that arrives while `busy` is high is ignored. The running sequence is unchanged.
- R9: A `start` with `byte_count` of zero gives a `done` pulse in the next cycle. `busy` stays low and `macro_ctrl` stays at 16'h0009.
- R10: A `wr_req` pulse gives a `wr_done` pulse in the next cycle. It has no effect on `macro_ctrl`, `busy`, `data_valid` or `data`.
- R11: One interval lasts ceil(`CLK_HZ`/1e6) cycles, with a minimum of 1. That is 13 cycles at 12.5 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Read request pulse |
| start_addr | input | 10 | First fuse byte address |
| byte_count | input | CNT_W | Number of bytes to read |
| wr_req | input | 1 | Write request (no effect on the macro) |
| fuse_q | input | 8 | Macro data output |
| busy | output | 1 | Read sequence in progress |
| data_valid | output | 1 | One-cycle pulse per returned byte |
| data | output | 8 | Returned byte |
| done | output | 1 | One-cycle end-of-request pulse |
| wr_done | output | 1 | One-cycle write acknowledge |
| macro_ctrl | output | 16 | Control word driven to the macro |

## Verification
The assertions assume that requests arrive one at a time. The single-cycle `done` check in particular assumes that a zero-length start is never followed at once by another zero-length start. The bench spaces all starts and write pulses at least two cycles apart. The address-step check assumes that `fuse_q` is a pure function of the presented address. The bench's stub derives each byte from the address field only while strobe is high and drives zero otherwise. Injected starts and writes during a session are single-cycle pulses, so the design's own cycle sequence stays the reference the bench predicts.

// File: rtl/fuse_read_pkg.sv
package fuse_read_pkg;

    localparam int FUSE_AW    = 10;
    localparam int CTRL_W     = 16;
    localparam int ADDR_LSB   = 6;
    localparam int BIT_PGM_N  = 3;
    localparam int BIT_LOAD   = 2;
    localparam int BIT_STROBE = 1;
    localparam int BIT_CS_N   = 0;

    typedef enum logic [2:0] {
        S_STANDBY,
        S_OPEN,
        S_ADDR_CLR,
        S_ADDR_SET,
        S_STROBE,
        S_RELEASE
    } seq_state_e;

    function automatic logic [CTRL_W-1:0] pack_ctrl(
        input logic              pgm_n,
        input logic              load,
        input logic              strobe,
        input logic              cs_n,
        input logic [FUSE_AW-1:0] addr
    );
        logic [CTRL_W-1:0] w;
        w = '0;
        w[ADDR_LSB +: FUSE_AW] = addr;
        w[BIT_PGM_N]           = pgm_n;
        w[BIT_LOAD]            = load;
        w[BIT_STROBE]          = strobe;
        w[BIT_CS_N]            = cs_n;
        return w;
    endfunction

endpackage

// File: rtl/fuse_gap_timer.sv
module fuse_gap_timer #(
    parameter int unsigned GAP_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int unsigned TW   = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
    localparam logic [TW-1:0] LAST = TW'(GAP_CYC - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);

endmodule

// File: rtl/fuse_addr_ctr.sv
module fuse_addr_ctr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/fuse_byte_ctr.sv
module fuse_byte_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign last = (left_q == CW'(1));

endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
    import fuse_read_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int          CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [FUSE_AW-1:0]  start_addr,
    input  logic [CNT_W-1:0]    byte_count,
    input  logic                wr_req,
    input  logic [7:0]          fuse_q,
    output logic                busy,
    output logic                data_valid,
    output logic [7:0]          data,
    output logic                done,
    output logic                wr_done,
    output logic [CTRL_W-1:0]   macro_ctrl
);
    localparam int unsigned GAP_RAW = (CLK_HZ + 999_999) / 1_000_000;
    localparam int unsigned GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;

    seq_state_e          state_q, state_d;
    logic                gap_end;
    logic                restart;
    logic                accept;
    logic                zero_req;
    logic                byte_step;
    logic                last_byte;
    logic [FUSE_AW-1:0]  cur_addr;

    logic                dv_q;
    logic [7:0]          data_q;
    logic                done_q;
    logic                wr_done_q;

    assign accept    = (state_q == S_STANDBY) && start && (byte_count != '0);
    assign zero_req  = (state_q == S_STANDBY) && start && (byte_count == '0);
    assign byte_step = (state_q == S_RELEASE) && gap_end;
    assign restart   = (state_d != state_q);

    fuse_gap_timer #(.GAP_CYC(GAP_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expired (gap_end)
    );

    fuse_addr_ctr #(.AW(FUSE_AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (start_addr),
        .step     (byte_step),
        .addr     (cur_addr)
    );

    fuse_byte_ctr #(.CW(CNT_W)) u_bytes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (byte_count),
        .dec      (byte_step),
        .last     (last_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_STANDBY:  if (accept)  state_d = S_OPEN;
            S_OPEN:     if (gap_end) state_d = S_ADDR_CLR;
            S_ADDR_CLR:              state_d = S_ADDR_SET;
            S_ADDR_SET: if (gap_end) state_d = S_STROBE;
            S_STROBE:   if (gap_end) state_d = S_RELEASE;
            S_RELEASE:  if (gap_end) state_d = last_byte ? S_STANDBY : S_ADDR_CLR;
            default:                 state_d = S_STANDBY;
        endcase
    end

    // Macro pin and busy decode
    always_comb begin
        macro_ctrl = pack_ctrl(1'b1, 1'b0, 1'b0, 1'b1, '0);
        busy       = 1'b1;
        unique case (state_q)
            S_STANDBY: begin
                macro_ctrl = pack_ctrl(1'b1, 1'b0, 1'b0, 1'b1, '0);
                busy       = 1'b0;
            end
            S_OPEN:     macro_ctrl = pack_ctrl(1'b1, 1'b1, 1'b0, 1'b0, '0);
            S_ADDR_CLR: macro_ctrl = pack_ctrl(1'b1, 1'b1, 1'b0, 1'b0, '0);
            S_ADDR_SET: macro_ctrl = pack_ctrl(1'b1, 1'b1, 1'b0, 1'b0, cur_addr);
            S_STROBE:   macro_ctrl = pack_ctrl(1'b1, 1'b1, 1'b1, 1'b0, cur_addr);
            S_RELEASE:  macro_ctrl = pack_ctrl(1'b1, 1'b1, 1'b0, 1'b0, cur_addr);
            default: begin
                macro_ctrl = pack_ctrl(1'b1, 1'b0, 1'b0, 1'b1, '0);
                busy       = 1'b0;
            end
        endcase
    end

    // Response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q      <= 1'b0;
            data_q    <= '0;
            done_q    <= 1'b0;
            wr_done_q <= 1'b0;
        end else begin
            dv_q      <= (state_q == S_STROBE) && gap_end;
            if ((state_q == S_STROBE) && gap_end) begin
                data_q <= fuse_q;
            end
            done_q    <= zero_req || (byte_step && last_byte);
            wr_done_q <= wr_req;
        end
    end

    assign data_valid = dv_q;
    assign data       = data_q;
    assign done       = done_q;
    assign wr_done    = wr_done_q;

endmodule

// File: rtl/fuse_read_seq_chk.sv
module fuse_read_seq_chk #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_req,
    input logic        busy,
    input logic        data_valid,
    input logic        done,
    input logic        wr_done,
    input logic [15:0] macro_ctrl
);
    localparam int unsigned GAP_RAW = (CLK_HZ + 999_999) / 1_000_000;
    localparam int unsigned GAP     = (GAP_RAW < 1) ? 1 : GAP_RAW;

    logic [31:0] strobe_run;
    logic [9:0]  prev_addr;
    logic        have_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_run <= '0;
            prev_addr  <= '0;
            have_prev  <= 1'b0;
        end else begin
            strobe_run <= macro_ctrl[1] ? strobe_run + 1 : 32'd0;
            if (!busy) begin
                have_prev <= 1'b0;
            end else if (macro_ctrl[1]) begin
                prev_addr <= macro_ctrl[15:6];
                have_prev <= 1'b1;
            end
        end
    end

    p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> macro_ctrl == 16'h0009);

    p_spare_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        macro_ctrl[5:4] == 2'b00);

    p_strobe_in_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        macro_ctrl[1] |-> (macro_ctrl[2] && macro_ctrl[3] && !macro_ctrl[0]));

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (macro_ctrl[1] && $past(macro_ctrl[1])) |-> $stable(macro_ctrl[15:6]));

    p_valid_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> ($past(macro_ctrl[1]) && !macro_ctrl[1]));

    p_strobe_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(macro_ctrl[1]) |-> strobe_run == GAP);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(macro_ctrl[1]) && have_prev) |-> macro_ctrl[15:6] == prev_addr + 10'd1);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_wr_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(wr_req));

endmodule

bind fuse_read_seq fuse_read_seq_chk #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (wr_req),
    .busy       (busy),
    .data_valid (data_valid),
    .done       (done),
    .wr_done    (wr_done),
    .macro_ctrl (macro_ctrl)
);

// File: tb/tb_fuse_read_seq.sv
module tb_fuse_read_seq;
    localparam int          CLK_PERIOD = 80;
    localparam int unsigned CLK_HZ     = 12_500_000;
    localparam int          G          = 13;   // ceil(12.5) cycles per 1 us interval

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  start_addr = '0;
    logic [15:0] byte_count = '0;
    logic        wr_req = 1'b0;
    logic [7:0]  fuse_q;
    logic        busy, data_valid, done, wr_done;
    logic [7:0]  data;
    logic [15:0] macro_ctrl;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] stub_val(input logic [9:0] a);
        return {a[1:0], a[9:4]} ^ 8'h5A;
    endfunction

    assign fuse_q = macro_ctrl[1] ? stub_val(macro_ctrl[15:6]) : 8'h00;

    fuse_read_seq #(.CLK_HZ(CLK_HZ), .CNT_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .wr_req(wr_req), .fuse_q(fuse_q),
        .busy(busy), .data_valid(data_valid), .data(data), .done(done),
        .wr_done(wr_done), .macro_ctrl(macro_ctrl)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected bytes as the design returns them (R4, R6)
    always @(negedge clk) begin
        if (rst_n && data_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected byte", {24'h0, data}, 32'h0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(data == e, "R4/R6 byte", {24'h0, data}, {24'h0, e});
            end
        end
    end

    // Driver: one read session, comparing the control word every cycle
    task automatic run_session(input logic [9:0] a, input int n, input bit inj_start, input bit inj_wr);
        int cyc = 0;
        int bad = 0;
        logic [15:0] first_act = '0, first_exp = '0;
        logic [15:0] seq[$];
        int open_len = 0;
        for (int i = 0; i < n; i++) exp_q.push_back(stub_val(10'(a + i)));
        for (int k = 0; k < G; k++) seq.push_back(16'h000C);
        for (int i = 0; i < n; i++) begin
            logic [9:0] ai;
            ai = 10'(a + i);
            seq.push_back(16'h000C);
            for (int k = 0; k < G; k++) seq.push_back({ai, 6'b001100});
            for (int k = 0; k < G; k++) seq.push_back({ai, 6'b001110});
            for (int k = 0; k < G; k++) seq.push_back({ai, 6'b001100});
        end
        @(negedge clk);
        start = 1'b1; start_addr = a; byte_count = 16'(n);
        @(negedge clk);
        start = 1'b0;
        while (cyc < seq.size()) begin
            if ((macro_ctrl != seq[cyc] || !busy) && bad == 0) begin
                first_act = macro_ctrl; first_exp = seq[cyc];
            end
            if (macro_ctrl != seq[cyc] || !busy) bad++;
            if (macro_ctrl == 16'h000C && cyc == open_len) open_len++;
            start  = inj_start && (cyc == 5);
            start_addr = inj_start ? 10'h3FF : a;
            byte_count = inj_start ? 16'd2 : 16'(n);
            wr_req = inj_wr && (cyc == 7);
            @(negedge clk);
            cyc++;
        end
        check(bad == 0, "R2/R3/R4/R5/R8/R10 ctrl sequence", {16'h0, first_act}, {16'h0, first_exp});
        check(open_len == G + 1, "R11 open+clear length", open_len, G + 1);
        check(macro_ctrl == 16'h0009, "R7 standby ctrl", {16'h0, macro_ctrl}, 32'h9);
        check(done == 1'b1 && busy == 1'b0, "R7 done with busy low", {30'h0, done, busy}, 32'h2);
        @(negedge clk);
        check(done == 1'b0, "R7 done single cycle", {31'h0, done}, 32'h0);
        check(exp_q.size() == 0, "R6 byte count", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(macro_ctrl == 16'h0009, "R1 reset ctrl", {16'h0, macro_ctrl}, 32'h9);
        check(!busy && !data_valid && !done && !wr_done, "R1 reset outputs",
              {28'h0, busy, data_valid, done, wr_done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(macro_ctrl == 16'h0009 && !busy, "R1 idle after reset", {16'h0, macro_ctrl}, 32'h9);

        run_session(10'd5, 3, 1'b0, 1'b0);          // R2..R7, R11
        run_session(10'h3FE, 4, 1'b0, 1'b0);        // R6 wrap 1022,1023,0,1
        run_session(10'h155, 1, 1'b1, 1'b1);        // R8 start while busy, R10 write while busy

        // R9 zero-length request
        @(negedge clk);
        start = 1'b1; byte_count = 16'd0; start_addr = 10'h0AA;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R9 done next cycle", {31'h0, done}, 32'h1);
        check(!busy && macro_ctrl == 16'h0009, "R9 macro stays standby", {15'h0, busy, macro_ctrl}, 32'h9);
        @(negedge clk);
        check(done == 1'b0 && !busy && macro_ctrl == 16'h0009, "R9 stays idle",
              {15'h0, done, macro_ctrl}, 32'h9);

        // R10 write in idle
        @(negedge clk);
        wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        check(wr_done == 1'b1, "R10 write ack", {31'h0, wr_done}, 32'h1);
        check(macro_ctrl == 16'h0009 && !busy && !data_valid, "R10 write no effect",
              {14'h0, busy, data_valid, macro_ctrl}, 32'h9);
        @(negedge clk);
        check(wr_done == 1'b0 && macro_ctrl == 16'h0009, "R10 ack single cycle",
              {15'h0, wr_done, macro_ctrl}, 32'h9);

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule